// File: doc/BRIEF.md
# Timer Count-Enable Prescaler with Configuration Freeze

This block makes the per-cycle count-enable for a timer/counter running on the system clock. The enable can come from a free-running 10-bit divider, with the undivided clock or one of four power-of-two taps selected. It can also come from a rising or falling edge seen on an external clock pin after a two-flop synchronizer and an edge detector. External edges never pass through the divider.

An 8-bit control register holds two live bits. Bit 0 is a divider-clear request. Bit 7 is a freeze mode. Without freeze, a 1 written to bit 0 clears the divider and drops back to 0 one cycle later. With freeze set, bit 0 keeps the value it was written with. While bit 0 is held at 1, no enable of any kind leaves the block. Firmware can therefore set up the timer with no risk of it advancing, then write 0 to bit 7 to restart counting from a clean divider.

Top module: `tmr_prescale_top`

## Requirements
- R1: After reset the control register reads 0x00 and `cnt_en` is 0.
- R2: A read returns the stored freeze bit (bit 7) and clear bit (bit 0). Bits 6..1 always read 0, and any value written to them has no effect.
- R3: A write with bit 0 = 1 and bit 7 = 0 makes bit 0 read 1 for exactly one cycle and 0 afterwards. The divider is zeroed, so the next tap pulse of period N appears N cycles after bit 0 returns to 0.
- R4: A write of bit 7 = 1 with bit 0 = 1 keeps bit 0 at 1 and the register at 0x81 for as long as no other write occurs.
- R5: A write of 0x00 clears both bits on the next edge, and the divider restarts from zero at that edge.
- R6: `clk_sel` = 3'b000 gives no enable.
- R7: `clk_sel` = 3'b001 gives an enable in every cycle in which bit 0 is 0.
- R8: `clk_sel` = 3'b010, 3'b011, 3'b100 and 3'b101 give one-cycle pulses every 8, 64, 256 and 1024 cycles. Each pulse falls in the cycle where the divider's low 3, 6, 8 or 10 bits are all ones.
- R9: `clk_sel` = 3'b111 gives exactly one enable per rising edge of `ext_clk_in`. The enable is seen in the cycle after the second clock edge that follows the input change. Falling edges give nothing.
- R10: `clk_sel` = 3'b110 gives exactly one enable per falling edge of `ext_clk_in`, with the same latency. Rising edges give nothing.
- R11: While bit 0 reads 1, `cnt_en` is 0 for every `clk_sel` value, including external-edge selections.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk_in | input | 1 | Asynchronous external clock pin |
| clk_sel | input | 3 | Enable source select |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| ctrl_rdata | output | 8 | Control register read value |
| cnt_en | output | 1 | Single-cycle count-enable for the timer |

## Verification
A stale divider value shows up as the first tap pulse after a clear landing on the wrong cycle. The sweeps track the exact cycle offset from the clear over two full periods of every tap, so such a fault appears within one tap period. A clear bit that fails to stick or to self-clear shows in the register read value one cycle after the write and in `cnt_en` staying low or high. A wrong synchronizer depth or edge polarity moves or misplaces the external enable within three cycles of an input change.

// File: rtl/pscl_pkg.sv
// Shared types and constants for the timer prescaler.
// Assumes the divider is at least as wide as the largest tap.
package pscl_pkg;

    typedef enum logic [2:0] {
        SEL_OFF      = 3'b000,
        SEL_DIV1     = 3'b001,
        SEL_DIV8     = 3'b010,
        SEL_DIV64    = 3'b011,
        SEL_DIV256   = 3'b100,
        SEL_DIV1024  = 3'b101,
        SEL_EXT_FALL = 3'b110,
        SEL_EXT_RISE = 3'b111
    } clk_sel_e;

    localparam int CTRL_W   = 8;
    localparam int FRZ_BIT  = 7;
    localparam int CLR_BIT  = 0;
    localparam int NUM_TAPS = 4;

    // Log2 of each tap period, smallest first.
    function automatic int tap_log(input int idx, input int cnt_w);
        case (idx)
            0:       tap_log = 3;
            1:       tap_log = 6;
            2:       tap_log = 8;
            default: tap_log = cnt_w;
        endcase
    endfunction

endpackage

// File: rtl/pscl_ctrl_reg.sv
// Control register: freeze bit and divider-clear bit.
// The clear bit self-clears one cycle after it is set unless freeze is set.
// Assumes writes are single-cycle strobes in the clk domain.
module pscl_ctrl_reg
    import pscl_pkg::*;
#(
    parameter int REG_W = CTRL_W,
    parameter int FRZ   = FRZ_BIT,
    parameter int CLR   = CLR_BIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             clr_hold
);

    localparam logic [REG_W-1:0] WR_MASK = (REG_W'(1) << FRZ) | (REG_W'(1) << CLR);

    logic [REG_W-1:0] reg_q;

    // Store the writable bits; release the clear bit when freeze is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else if (wr) begin
            reg_q <= wdata & WR_MASK;
        end else if (!reg_q[FRZ]) begin
            reg_q[CLR] <= 1'b0;
        end
    end

    // Expose the stored state for reads and to the divider.
    always_comb begin
        rdata    = reg_q;
        clr_hold = reg_q[CLR];
    end

endmodule

// File: rtl/pscl_divider.sv
// Free-running binary divider with one pulse output per tap.
// A tap fires in the cycle its low bits are all ones, so the pulse comes
// one full period after a clear. Assumes tap_log() never exceeds CNT_W.
module pscl_divider
    import pscl_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int NTAP  = NUM_TAPS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    output logic [NTAP-1:0] tap
);

    logic [CNT_W-1:0] cnt_q;

    // Count every cycle; zero while the clear request is present.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    for (genvar g = 0; g < NTAP; g++) begin : g_tap
        localparam int LOGN = tap_log(g, CNT_W);
        // Tap pulse when the low LOGN bits are about to wrap.
        always_comb tap[g] = &cnt_q[LOGN-1:0];
    end

endmodule

// File: rtl/pscl_edge_sync.sv
// Synchronizer chain plus one edge-detect register for an async pin.
// An input change shows as a one-cycle rise/fall after STAGES clock edges.
// Assumes the pin stays stable for at least two clk cycles per level.
module pscl_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);

    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] chain_q;

    // Shift the pin through the synchronizer and the history register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[DEPTH-2:0], pin};
        end
    end

    // Compare the newest synchronized sample with the previous one.
    always_comb begin
        rise = chain_q[STAGES-1] & ~chain_q[STAGES];
        fall = ~chain_q[STAGES-1] & chain_q[STAGES];
    end

endmodule

// File: rtl/tmr_prescale_top.sv
// Timer count-enable generator: selects the divider tap, the undivided clock
// or a synchronized external edge, and gates everything off while the clear
// bit of the control register is set. Assumes a single clock domain apart
// from ext_clk_in.
module tmr_prescale_top
    import pscl_pkg::*;
#(
    parameter int CNT_W     = 10,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk_in,
    input  logic [2:0]        clk_sel,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    output logic              cnt_en
);

    logic                clr_hold;
    logic [NUM_TAPS-1:0] tap;
    logic                ext_rise;
    logic                ext_fall;
    logic                en_raw;

    pscl_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (ctrl_wr),
        .wdata    (ctrl_wdata),
        .rdata    (ctrl_rdata),
        .clr_hold (clr_hold)
    );

    pscl_divider #(.CNT_W(CNT_W), .NTAP(NUM_TAPS)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clr_hold),
        .tap   (tap)
    );

    pscl_edge_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_clk_in),
        .rise  (ext_rise),
        .fall  (ext_fall)
    );

    // Pick the enable source named by clk_sel.
    always_comb begin
        case (clk_sel_e'(clk_sel))
            SEL_OFF:      en_raw = 1'b0;
            SEL_DIV1:     en_raw = 1'b1;
            SEL_DIV8:     en_raw = tap[0];
            SEL_DIV64:    en_raw = tap[1];
            SEL_DIV256:   en_raw = tap[2];
            SEL_DIV1024:  en_raw = tap[3];
            SEL_EXT_FALL: en_raw = ext_fall;
            default:      en_raw = ext_rise;
        endcase
    end

    // Suppress every source while the clear bit is set.
    always_comb cnt_en = en_raw & ~clr_hold;

endmodule

// File: rtl/pscl_chk.sv
// Port-level properties of the prescaler, bound into the top module.
module pscl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] clk_sel,
    input logic       ctrl_wr,
    input logic       wr_frz,
    input logic       wr_clr,
    input logic [7:0] ctrl_rdata,
    input logic       cnt_en
);

    // R11
    held_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[0] |-> !cnt_en);

    // R4
    frz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata[7] && ctrl_rdata[0] && !ctrl_wr) |=> ctrl_rdata[0]);

    // R3
    auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_rdata[7] && ctrl_rdata[0] && !ctrl_wr) |=> !ctrl_rdata[0]);

    // R5
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wr_frz && !wr_clr) |=> (ctrl_rdata == 8'h00));

    // R6
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'b000) |-> !cnt_en);

    // R7
    div1_every_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'b001 && !ctrl_rdata[0]) |-> cnt_en);

    // R2
    spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (ctrl_rdata[6:1] == 6'd0));

endmodule

bind tmr_prescale_top pscl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_sel    (clk_sel),
    .ctrl_wr    (ctrl_wr),
    .wr_frz     (ctrl_wdata[7]),
    .wr_clr     (ctrl_wdata[0]),
    .ctrl_rdata (ctrl_rdata),
    .cnt_en     (cnt_en)
);

// File: tb/tmr_prescale_top_test.sv
`timescale 1ns/1ps
module tmr_prescale_top_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk_in = 1'b0;
    logic [2:0] clk_sel = 3'b000;
    logic       ctrl_wr = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00;
    logic [7:0] ctrl_rdata;
    logic       cnt_en;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tmr_prescale_top uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_clk_in (ext_clk_in),
        .clk_sel    (clk_sel),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .ctrl_rdata (ctrl_rdata),
        .cnt_en     (cnt_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Write at a falling edge; returns at the falling edge after the write edge.
    task automatic wr_reg(input logic [7:0] d);
        ctrl_wr    = 1'b1;
        ctrl_wdata = d;
        step();
        ctrl_wr    = 1'b0;
        ctrl_wdata = 8'h00;
    endtask

    // R3, R8: pulse clear, then sweep two periods counting mismatches.
    task automatic tap_sweep(input logic [2:0] sel, input int period, input string req);
        int miss = 0;
        clk_sel = sel;
        wr_reg(8'h01);
        chk("R3 clear reads 1", int'(ctrl_rdata), 1);
        chk("R11 no enable while clear", int'(cnt_en), 0);
        step();
        chk("R3 clear self-released", int'(ctrl_rdata), 0);
        for (int j = 0; j < 2 * period + 4; j++) begin
            if (int'(cnt_en) != int'((j % period) == period - 1)) miss++;
            step();
        end
        chk(req, miss, 0);
    endtask

    // R9, R10: toggle the pin every three cycles, expect enable on 2nd sample.
    task automatic ext_sweep(input logic [2:0] sel, input logic want_rise, input string req);
        int miss = 0;
        clk_sel = sel;
        repeat (4) step();
        for (int e = 0; e < 10; e++) begin
            ext_clk_in = ~ext_clk_in;
            for (int k = 1; k <= 3; k++) begin
                step();
                if (int'(cnt_en) != int'(k == 2 && ext_clk_in == want_rise)) miss++;
            end
        end
        chk(req, miss, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 reset register", int'(ctrl_rdata), 0);
        chk("R1 reset enable", int'(cnt_en), 0);

        // R6
        begin
            int miss = 0;
            for (int j = 0; j < 40; j++) begin
                if (cnt_en) miss++;
                step();
            end
            chk("R6 select off", miss, 0);
        end

        // R7
        begin
            int miss = 0;
            clk_sel = 3'b001;
            wr_reg(8'h01);
            chk("R11 div1 blocked by clear", int'(cnt_en), 0);
            step();
            for (int j = 0; j < 40; j++) begin
                if (!cnt_en) miss++;
                step();
            end
            chk("R7 undivided", miss, 0);
        end

        tap_sweep(3'b010, 8,    "R8 div8 pulses");
        tap_sweep(3'b011, 64,   "R8 div64 pulses");
        tap_sweep(3'b100, 256,  "R8 div256 pulses");
        tap_sweep(3'b101, 1024, "R8 div1024 pulses");

        // R2
        wr_reg(8'h7E);
        chk("R2 spare bits ignored", int'(ctrl_rdata), 0);
        wr_reg(8'hFF);
        chk("R2 only live bits stored", int'(ctrl_rdata), 8'h81);
        wr_reg(8'h80);
        chk("R2 freeze with clear 0", int'(ctrl_rdata), 8'h80);
        step();
        chk("R2 freeze readback stable", int'(ctrl_rdata), 8'h80);

        // R4, R11
        begin
            int miss_r = 0;
            int miss_e = 0;
            clk_sel = 3'b001;
            wr_reg(8'h81);
            for (int j = 0; j < 30; j++) begin
                if (ctrl_rdata != 8'h81) miss_r++;
                if (cnt_en) miss_e++;
                step();
            end
            chk("R4 clear held under freeze", miss_r, 0);
            chk("R11 div1 silent while held", miss_e, 0);
            clk_sel = 3'b111;
            for (int e = 0; e < 6; e++) begin
                ext_clk_in = ~ext_clk_in;
                for (int k = 0; k < 3; k++) begin
                    if (cnt_en) miss_e++;
                    step();
                end
            end
            repeat (4) step();
            chk("R11 external edges silent while held", miss_e, 0);
        end

        // R5: release restarts divider from zero at the write edge.
        begin
            int miss = 0;
            clk_sel = 3'b010;
            wr_reg(8'h00);
            chk("R5 release clears both bits", int'(ctrl_rdata), 0);
            for (int j = 0; j < 20; j++) begin
                if (int'(cnt_en) != int'((j % 8) == 7)) miss++;
                step();
            end
            chk("R5 counting restarts from zero", miss, 0);
        end

        ext_clk_in = 1'b0;
        clk_sel = 3'b000;
        repeat (4) step();
        ext_sweep(3'b111, 1'b1, "R9 rising edges");
        ext_sweep(3'b110, 1'b0, "R10 falling edges");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule